// File: doc/BRIEF.md
# Sync-Triggered Armed Capture Buffer

This block sits beside a streaming data path that carries a data word, a valid strobe and a sync pulse. It takes a snapshot of that stream once per arming. Software first sets a skip count and then arms the block through a small register port. The block then waits for a sync pulse. From the sync cycle on, it counts valid cycles. Once the programmed number has gone by, it stores the next `NWORDS` valid words into an internal RAM and stops.

Software polls a status register until the done flag is set. It then reads the stored words back through the same register port. The RAM keeps its contents until software arms the block again.

Top module: `cap_buf`

## Requirements
- R1: A synchronous active-high reset puts the block in the idle state: status reads 0, the skip register reads 0, and the read-valid output is low.
- R2: A bus write to offset 0 with data bit 0 set arms the block, but only when it is idle or done. The status then reads 1 (waiting for sync), and any earlier done flag is cleared.
- R3: While waiting, valid data without a sync pulse is not stored, and the status stays at 1.
- R4: Valid cycles are counted starting with the sync cycle itself. The first D of them are skipped, where D is the value at offset 1. Cycles with valid low are not counted. While skipping, the status reads 2.
- R5: With D equal to 0, the valid word in the sync cycle is stored at RAM word 0, and the status then reads 4 (capturing).
- R6: Exactly `NWORDS` valid words are stored, in arrival order, at bus offsets `BASE`, `BASE+1`, and so on. After the last one the status reads 8 (done).
- R7: A sync pulse or an arm write that arrives while skipping or capturing has no effect on which words are stored.
- R8: Once done, the RAM does not change, whatever arrives on the stream, until the block is armed again.
- R9: A read request returns its data with read-valid high exactly one cycle later. RAM words are zero-extended above `DATA_W`. Offset 1 reads back the skip count. Unmapped offsets read 0.
- R10: At most one status bit is set at any time: bit 0 waiting, bit 1 skipping, bit 2 capturing, bit 3 done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Stream data word |
| in_valid | input | 1 | Stream data valid |
| in_sync | input | 1 | Stream sync pulse |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | DLY_W | Register write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |

## Verification
The hardest situations to reach are a second sync pulse or a repeated arm write that lands in the middle of a skip or capture window. Both must leave the stored words untouched. The bench records every valid word from the first sync on. It then raises extra sync pulses at random during the rest of the run, and in some runs issues arm writes just after capture has begun. The readback must still match the recorded words, shifted by the skip count. Skip counts of 0, 1 and well above the RAM depth are combined with valid densities from sparse to full. This exercises both the sync-cycle corner case and the rule that only valid cycles are counted.

// File: rtl/cap_buf.sv
module cap_buf #(
  parameter int DATA_W = 12,
  parameter int NWORDS = 8,
  parameter int DLY_W  = 16,
  parameter int ADDR_W = 6,
  parameter int BASE   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sync,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DLY_W-1:0]  bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [ADDR_W-1:0] A_ARM  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SKIP = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SKIP, S_CAP, S_DONE} st_t;

  st_t               st;
  logic [DLY_W-1:0]  skip_reg;
  logic [DLY_W-1:0]  skip_left;
  logic [IW-1:0]     wcnt;
  logic [DATA_W-1:0] mem [NWORDS];
  logic              mem_we;
  logic [IW-1:0]     mem_idx;
  logic              last_word;
  logic [3:0]        stat4;
  logic              arm_req;
  logic              ram_hit;
  logic [IW-1:0]     rd_idx;
  logic [31:0]       rd_mux;

  assign arm_req   = bus_wr && bus_addr == A_ARM && bus_wdata[0];
  assign stat4     = {st == S_DONE, st == S_CAP, st == S_SKIP, st == S_WAIT};
  assign last_word = int'(mem_idx) == NWORDS - 1;

  always_comb begin
    mem_we  = 1'b0;
    mem_idx = wcnt;
    case (st)
      S_WAIT: if (in_sync && skip_reg == '0 && in_valid) begin
        mem_we  = 1'b1;
        mem_idx = '0;
      end
      S_CAP: mem_we = in_valid;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      skip_reg  <= '0;
      skip_left <= '0;
      wcnt      <= '0;
    end else begin
      if (bus_wr && bus_addr == A_SKIP) skip_reg <= bus_wdata;
      case (st)
        S_IDLE, S_DONE: if (arm_req) begin
          st   <= S_WAIT;
          wcnt <= '0;
        end
        S_WAIT: if (in_sync) begin
          if (skip_reg == '0) begin
            if (mem_we) begin
              st   <= last_word ? S_DONE : S_CAP;
              wcnt <= IW'(1);
            end else begin
              st   <= S_CAP;
              wcnt <= '0;
            end
          end else begin
            skip_left <= skip_reg - DLY_W'(in_valid);
            st        <= (skip_reg == DLY_W'(1) && in_valid) ? S_CAP : S_SKIP;
          end
        end
        S_SKIP: if (in_valid) begin
          skip_left <= skip_left - DLY_W'(1);
          if (skip_left == DLY_W'(1)) st <= S_CAP;
        end
        S_CAP: if (in_valid) begin
          wcnt <= wcnt + IW'(1);
          if (last_word) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_idx] <= in_data;
  end

  assign ram_hit = int'(bus_addr) >= BASE && int'(bus_addr) < BASE + NWORDS;
  assign rd_idx  = IW'(int'(bus_addr) - BASE);

  always_comb begin
    rd_mux = '0;
    if (ram_hit)                 rd_mux = 32'(mem[rd_idx]);
    else if (bus_addr == A_SKIP) rd_mux = 32'(skip_reg);
    else if (bus_addr == A_STAT) rd_mux = 32'(stat4);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cap_buf_chk.sv
module cap_buf_chk #(
  parameter int DLY_W  = 16,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_sync,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DLY_W-1:0]  bus_wdata,
  input logic              bus_rvalid,
  input logic [3:0]        stat,
  input logic              mem_we
);
  logic arm;
  assign arm = bus_wr && bus_addr == '0 && bus_wdata[0];

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (stat == 4'd0 && !bus_rvalid));
  // R2
  arm_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat == 4'd0 || stat[3]) && arm) |=> stat == 4'd1);
  // R3
  hold_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (stat[0] && !in_sync) |=> stat[0]);
  // R6
  write_valid_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> in_valid);
  // R7
  write_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (stat[2] || (stat[0] && in_sync)));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat[3] && !arm) |=> stat[3]);
  // R8
  done_nowrite_chk: assert property (@(posedge clk) disable iff (rst) stat[3] |-> !mem_we);
  // R9
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst) bus_rd |=> bus_rvalid);
  // R9
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst) !bus_rd |=> !bus_rvalid);
  // R10
  stat_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(stat));
endmodule

bind cap_buf cap_buf_chk #(.DLY_W(DLY_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sync(in_sync),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rvalid(bus_rvalid), .stat(stat4), .mem_we(mem_we)
);

// File: tb/cap_buf_tb_top.sv
module cap_buf_tb_top;
  localparam int DW = 12, NW = 8, DLW = 16, AW = 6, BASE = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, in_valid, in_sync, bus_wr, bus_rd, bus_rvalid;
  logic [DW-1:0]  in_data;
  logic [AW-1:0]  bus_addr;
  logic [DLW-1:0] bus_wdata;
  logic [31:0]    bus_rdata;

  int total = 0, bad = 0;
  bit finished = 0;
  bit logging = 0, arm_now = 0;
  logic [DW-1:0] log_q[$];

  cap_buf #(.DATA_W(DW), .NWORDS(NW), .DLY_W(DLW), .ADDR_W(AW), .BASE(BASE)) dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_sync(in_sync),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

  function automatic logic [31:0] exp_word(int d, int k);
    return 32'(log_q[d + k]);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 0; in_sync = 0; bus_wr = 0; bus_rd = 0;
    @(negedge clk);
  endtask

  task automatic drive(bit s, int pct);
    in_valid  = int'($urandom % 100) < pct;
    in_data   = DW'($urandom);
    in_sync   = s;
    bus_wr    = arm_now;
    bus_addr  = '0;
    bus_wdata = DLW'(1);
    arm_now   = 0;
    if (s) logging = 1;
    if (logging && in_valid) log_q.push_back(in_data);
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1; bus_addr = AW'(a); bus_wdata = DLW'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    bus_rd = 1; bus_addr = AW'(a);
    @(negedge clk);
    chk(bus_rvalid === 1'b1, "R9 rvalid", 32'(bus_rvalid), 1);
    v = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic run(int d, int pct, bit extra_sync, bit arm_mid);
    logic [31:0] v;
    logic [31:0] snap[NW];
    wr(1, d);
    rd(1, v); chk(v == 32'(d), "R9 skip readback", v, 32'(d));
    wr(0, 1);
    rd(2, v); chk(v == 1, "R2 armed", v, 1);
    logging = 0;
    repeat (3 + $urandom % 6) drive(0, pct);
    idle();
    rd(2, v); chk(v == 1, "R3 still waiting", v, 1);
    log_q.delete();
    drive(1, pct);
    if (d >= 4) begin
      idle(); rd(2, v); chk(v == 2, "R4 skipping", v, 2);
    end else if (d == 0) begin
      idle(); rd(2, v); chk(v == 4, "R5 capturing", v, 4);
    end
    while (log_q.size() < d + NW) begin
      if (arm_mid && log_q.size() == d + 1) arm_now = 1;
      drive(extra_sync && ($urandom % 4 == 0), pct);
    end
    logging = 0;
    idle();
    rd(2, v); chk(v == 8, "R6 done", v, 8);
    for (int k = 0; k < NW; k++) begin
      rd(BASE + k, v);
      chk(v == exp_word(d, k), "R4/R6/R7 stored word", v, exp_word(d, k));
      snap[k] = v;
    end
    repeat (12) drive($urandom % 3 == 0, 90);
    idle();
    rd(2, v); chk(v == 8, "R8 done held", v, 8);
    for (int k = 0; k < NW; k++) begin
      rd(BASE + k, v);
      chk(v == snap[k], "R8 word held", v, snap[k]);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst = 1; in_valid = 0; in_sync = 0; in_data = '0;
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    chk(bus_rvalid === 1'b0, "R1 rvalid low", 32'(bus_rvalid), 0);
    rst = 0;
    @(negedge clk);
    rd(2, v); chk(v == 0, "R1 status idle", v, 0);
    rd(1, v); chk(v == 0, "R1 skip zero", v, 0);
    rd(5, v); chk(v == 0, "R9 unmapped", v, 0);
    rd(BASE + NW, v); chk(v == 0, "R9 past ram", v, 0);
    run(0, 100, 0, 0);
    run(0, 40, 1, 1);
    run(1, 100, 0, 0);
    run(3, 50, 1, 0);
    run(20, 70, 1, 1);
    for (int i = 0; i < 6; i++)
      run(int'($urandom % 10), 30 + int'($urandom % 70), bit'($urandom % 2), bit'($urandom % 2));
    summary();
  end
endmodule